// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block takes eight interrupt request lines, keeps a record of which ones are waiting, and raises a single interrupt output towards a processor. The output rises only when an unmasked waiting request outranks everything already being serviced. When the processor answers with an acknowledge pulse, the block picks the winning request and moves it from waiting to in service. One cycle later it presents an 8-bit vector formed by adding the request number to a programmable base.

Software reaches the block through a byte-wide register port with a single address bit. Address 0 is the command port and address 1 is the data port. A start command on the command port opens a three-word setup sequence on the data port. The setup sets the vector base, a set of lines that lead to a downstream controller, and a mode word. Outside setup, the data port reads and writes the mask. Command-port writes either end service of a level or choose which status register the command port returns on a read. An acknowledge with nothing eligible returns the lowest-priority vector and leaves the service state untouched.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service registers are zero, `int_o` is low, the vector base is 0 and requests are edge-sensitive.
- R2: With `addr_i`=0 a write goes to the command port; with `addr_i`=1 it goes to the data port. Outside setup, a data-port write loads the mask and a data-port read returns it.
- R3: In edge mode a pending bit is set by a rising edge on its input. It stays set when the input falls and clears only when that input is acknowledged.
- R4: A command-port write with bit 4 set starts setup. It takes level mode from bit 3, clears mask, pending and in-service, and selects pending for command-port reads. The next three data writes load the base, the downstream-line mask and the mode word. `int_o` stays low until the third word.
- R5: One cycle after the acknowledge cycle, `vec_valid_o` is high for exactly one cycle. `vec_o` then equals (base + input number) modulo 256.
- R6: Priority is fixed with input 0 highest. `int_o` is high only when an unmasked pending bit has a lower index than every set in-service bit, or when no in-service bit is set.
- R7: On acknowledge, the winning bit is cleared from the pending register and set in the in-service register.
- R8: If no request is eligible under R6 at acknowledge, the vector is base + 7. The pending and in-service registers are left unchanged.
- R9: A command-port write with bits 4 and 3 clear is an end-of-service command. Bits 7:5 = 001 clear the lowest-index in-service bit. Bits 7:5 = 011 clear the in-service bit numbered by bits 2:0. Any other code changes nothing.
- R10: A command-port write with bit 4 clear and bit 3 set is a read-select command. If its bit 1 is set, bit 0 picks the source of command-port reads (0 pending, 1 in-service). If bit 1 is clear, the selection is kept.
- R11: In level mode a pending bit follows its input level, so a request that drops before acknowledge disappears.
- R12: `slave_o` is high together with `vec_valid_o` when the serviced input is flagged in the downstream-line mask. It is low for the R8 vector.
- R13: When bit 1 of the mode word is set, an acknowledge does not set any in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Interrupt request lines, index 0 highest priority |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Port select: 0 command, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port selected by `addr_i` |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request towards the processor |
| vec_o | output | 8 | Vector returned after acknowledge |
| vec_valid_o | output | 1 | Marks the cycle in which `vec_o` is valid |
| slave_o | output | 1 | Serviced input leads to a downstream controller |

## Verification
Acknowledges are driven with one waiting request, with two new requests on either side of an active service level, and with only a lower-ranked request left. These cases separate correct priority from plain pending selection and expose a spurious vector. End-of-service commands are sent as the non-specific form, the numbered form and an unused code, which shows which in-service bit each one touches. The level-mode run with a base near the top of the vector range separates level from edge latching, checks modulo wrap of the vector sum, and confirms that in-service is not recorded under the mode-word option.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    parameter int IRQ_N  = 8;
    parameter int DATA_W = 8;
    localparam int IDX_W = $clog2(IRQ_N);

    typedef enum logic [1:0] {
        SETUP_IDLE,
        SETUP_BASE,
        SETUP_LINES,
        SETUP_MODE
    } setup_e;

    typedef struct packed {
        logic [IRQ_N-1:0]  imr;
        logic [IRQ_N-1:0]  isr;
        logic [IRQ_N-1:0]  lines;
        logic [DATA_W-1:0] base;
        logic              level;
        logic              auto_end;
        logic              rd_isr;
        setup_e            setup;
        logic [DATA_W-1:0] vec;
        logic              vec_v;
        logic              slave;
    } ctrl_s;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic         level_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_d, prev_q;
    logic [N-1:0] pend_d, pend_q;
    logic [N-1:0] rise;

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = irq_i[g] & ~prev_q[g];
    end

    always_comb begin
        prev_d = irq_i;
        if (level_i) begin
            pend_d = irq_i & ~clr_i;
        end else begin
            pend_d = (pend_q & ~clr_i) | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !level_i |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R3
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] isr_i,
    output logic [IW-1:0] win_idx_o,
    output logic [IW-1:0] isr_top_o,
    output logic          isr_any_o,
    output logic          raise_o
);
    logic [N-1:0] elig;
    logic         win_any;

    assign elig = pend_i & ~mask_i;

    always_comb begin
        win_idx_o = '0;
        win_any   = 1'b0;
        isr_top_o = '0;
        isr_any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx_o = IW'(i);
                win_any   = 1'b1;
            end
            if (isr_i[i]) begin
                isr_top_o = IW'(i);
                isr_any_o = 1'b1;
            end
        end
        raise_o = win_any && (!isr_any_o || (win_idx_o < isr_top_o));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_N-1:0]  irq_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              inta_i,
    output logic              int_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_valid_o,
    output logic              slave_o
);
    ctrl_s q, d;

    logic [IRQ_N-1:0] pend;
    logic [IRQ_N-1:0] clr;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] isr_top;
    logic             isr_any;
    logic             raise;
    logic             svc;
    logic             wr_cmd, wr_dat;
    logic             cmd_setup, cmd_end, cmd_sel;

    irq_req_latch #(.N(IRQ_N)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .level_i (q.level),
        .clr_i   (clr),
        .pend_o  (pend)
    );

    irq_resolver #(.N(IRQ_N)) u_resolve (
        .pend_i    (pend),
        .mask_i    (q.imr),
        .isr_i     (q.isr),
        .win_idx_o (win_idx),
        .isr_top_o (isr_top),
        .isr_any_o (isr_any),
        .raise_o   (raise)
    );

    assign wr_cmd    = wr_i && !addr_i;
    assign wr_dat    = wr_i && addr_i;
    assign cmd_setup = wr_cmd && wdata_i[4];
    assign cmd_end   = wr_cmd && !wdata_i[4] && !wdata_i[3];
    assign cmd_sel   = wr_cmd && !wdata_i[4] && wdata_i[3];
    assign svc       = inta_i && raise && (q.setup == SETUP_IDLE);

    always_comb begin
        d       = q;
        d.vec_v = 1'b0;
        d.slave = 1'b0;
        clr     = '0;

        if (inta_i) begin
            d.vec_v = 1'b1;
            if (svc) begin
                d.vec      = q.base + DATA_W'(win_idx);
                d.slave    = q.lines[win_idx];
                clr[win_idx] = 1'b1;
                if (!q.auto_end) begin
                    d.isr[win_idx] = 1'b1;
                end
            end else begin
                d.vec = q.base + DATA_W'(IRQ_N - 1);
            end
        end

        if (cmd_setup) begin
            d.setup  = SETUP_BASE;
            d.level  = wdata_i[3];
            d.imr    = '0;
            d.isr    = '0;
            d.rd_isr = 1'b0;
            clr      = '1;
        end else if (cmd_end) begin
            case (wdata_i[7:5])
                3'b001: begin
                    if (isr_any) begin
                        d.isr[isr_top] = 1'b0;
                    end
                end
                3'b011: d.isr[wdata_i[IDX_W-1:0]] = 1'b0;
                default: ;
            endcase
        end else if (cmd_sel && wdata_i[1]) begin
            d.rd_isr = wdata_i[0];
        end

        if (wr_dat) begin
            case (q.setup)
                SETUP_IDLE:  d.imr = wdata_i[IRQ_N-1:0];
                SETUP_BASE: begin
                    d.base  = wdata_i;
                    d.setup = SETUP_LINES;
                end
                SETUP_LINES: begin
                    d.lines = wdata_i[IRQ_N-1:0];
                    d.setup = SETUP_MODE;
                end
                SETUP_MODE: begin
                    d.auto_end = wdata_i[1];
                    d.setup    = SETUP_IDLE;
                end
                default: d.setup = SETUP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.imr      <= '1;
            q.setup    <= SETUP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign int_o       = raise && (q.setup == SETUP_IDLE);
    assign vec_o       = q.vec;
    assign vec_valid_o = q.vec_v;
    assign slave_o     = q.slave;
    assign rdata_o     = addr_i ? DATA_W'(q.imr)
                                : (q.rd_isr ? DATA_W'(q.isr) : DATA_W'(pend));

    AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((pend & ~q.imr) != '0)); // R6
    AST_ACK_ADDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !q.auto_end && !wr_i) |=> ($countones(q.isr) == $countones($past(q.isr)) + 1)); // R7
    AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !raise && !wr_i) |=> (q.isr == $past(q.isr))); // R8
    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && !inta_i) |=> !vec_valid_o); // R5
    AST_SLAVE_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        slave_o |-> vec_valid_o); // R12
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       wr_i = 1'b0;
    logic       addr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       inta_i = 1'b0;
    logic       int_o;
    logic [7:0] vec_o;
    logic       vec_valid_o;
    logic       slave_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] vec; logic slv; string tag; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .inta_i(inta_i), .int_o(int_o),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o), .slave_o(slave_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = v;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_i = v;
        @(negedge clk);
    endtask

    task automatic ack(input logic [7:0] ev, input logic es, input string tag);
        exp_t e;
        e.vec = ev; e.slv = es; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        inta_i = 1'b1;
        @(negedge clk);
        inta_i = 1'b0;
    endtask

    // monitor: pops expected vectors as the design presents them
    always @(negedge clk) begin
        if (rst_n && vec_valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R5 unexpected vector actual=%0h expected=none", vec_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " vector"}, 32'(vec_o), 32'(e.vec));
                chk({e.tag, " R12 slave flag"}, 32'(slave_o), 32'(e.slv));
            end
        end
    end

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(1'b1, r); chk("R1 mask after reset", r, 8'hFF);
        rd(1'b0, r); chk("R1 pending after reset", r, 8'h00);
        chk("R1 int_o after reset", int_o, 1'b0);
        ack(8'h07, 1'b0, "R1 base zero spurious");

        // setup: edge mode, base 0x20, line 2 downstream, no auto end
        wr(1'b0, 8'h10);
        set_irq(8'h20);
        chk("R4 int_o low during setup", int_o, 1'b0);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        chk("R4 int_o low before last word", int_o, 1'b0);
        wr(1'b1, 8'h00);
        chk("R6 int_o after setup", int_o, 1'b1);
        rd(1'b1, r); chk("R4 mask cleared", r, 8'h00);
        rd(1'b0, r); chk("R3 pending latched", r, 8'h20);

        ack(8'h25, 1'b0, "R5 base plus five");
        rd(1'b0, r); chk("R7 pending cleared, R3 no relatch", r, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R7 R10 in-service set", r, 8'h20);
        chk("R6 int_o idle", int_o, 1'b0);
        wr(1'b0, 8'h0A);

        set_irq(8'h68);
        rd(1'b0, r); chk("R3 two rising edges", r, 8'h48);
        chk("R6 higher outranks service", int_o, 1'b1);
        ack(8'h23, 1'b0, "R6 R7 winner input 3");
        chk("R6 lower blocked by service", int_o, 1'b0);
        ack(8'h27, 1'b0, "R8 spurious");
        rd(1'b0, r); chk("R8 pending kept", r, 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R8 in-service kept", r, 8'h28);

        wr(1'b0, 8'h20);
        rd(1'b0, r); chk("R9 non-specific end", r, 8'h20);
        chk("R6 still blocked", int_o, 1'b0);
        wr(1'b0, 8'h65);
        rd(1'b0, r); chk("R9 numbered end", r, 8'h00);
        chk("R6 raised after end", int_o, 1'b1);

        wr(1'b1, 8'h40);
        rd(1'b1, r); chk("R2 mask write read", r, 8'h40);
        chk("R6 masked request", int_o, 1'b0);
        wr(1'b1, 8'h00);
        chk("R6 unmasked request", int_o, 1'b1);

        set_irq(8'h28);
        wr(1'b0, 8'h0A);
        rd(1'b0, r); chk("R3 held after input fall", r, 8'h40);
        ack(8'h26, 1'b0, "R5 base plus six");
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R9 unused code ignored", r, 8'h40);
        wr(1'b0, 8'h08);
        rd(1'b0, r); chk("R10 selection kept", r, 8'h40);
        wr(1'b0, 8'h20);
        rd(1'b0, r); chk("R9 end clears last", r, 8'h00);

        set_irq(8'h2C);
        ack(8'h22, 1'b1, "R12 downstream line");
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // setup: level mode, base 0xFC, auto end
        wr(1'b0, 8'h18);
        wr(1'b1, 8'hFC);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        rd(1'b1, r); chk("R4 mask cleared again", r, 8'h00);
        set_irq(8'h10);
        rd(1'b0, r); chk("R11 level follows high", r, 8'h10);
        chk("R11 int_o level", int_o, 1'b1);
        set_irq(8'h00);
        rd(1'b0, r); chk("R11 level follows low", r, 8'h00);
        chk("R11 int_o dropped", int_o, 1'b0);
        set_irq(8'h10);
        ack(8'h00, 1'b0, "R5 wrap");
        wr(1'b0, 8'h0B);
        rd(1'b0, r); chk("R13 no in-service", r, 8'h00);
        set_irq(8'h00);

        repeat (2) @(negedge clk);
        chk("R5 all vectors seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule